// File: doc/BRIEF.md
# Banked Internal Data Memory Decoder

This block is the internal data-space access unit of an 8051-style core. Each request carries an 8-bit address, an access mode and a write strobe. The block resolves the request to a byte of its own 256-byte internal RAM, to an entry on an external special-function register port, or to a single bit inside one of those bytes. The two bank-select bits of the status word pick which group of eight working registers the register and pointer accesses see.

Byte reads are combinational. `rdata_o` is valid in the same cycle as the request, and byte writes commit at the next rising edge. A bit write is a read-modify-write that is spread over two clocks. At the first edge the block captures the target byte with the new bit merged in. During the following cycle `busy_o` is high, and the merged byte is written at the second edge. Requests presented while `busy_o` is high are dropped. The stack mode lets push and pop use the stack pointer directly as an indirect RAM address.

Top module: `idata_access_unit`

## Requirements
- R1: Register mode (mode 0) reaches RAM byte bank*8 + addr[2:0], where bank is `bank_i` and the bank occupies RAM bytes 0 to 31.
- R2: Direct mode (mode 1) with addr below 80h reads and writes RAM at addr and leaves `sfr_rd_o` and `sfr_we_o` low. With addr 80h or above, a direct read asserts `sfr_rd_o` and returns `sfr_rdata_i` for `sfr_addr_o` = addr.
- R3: Indirect mode (mode 2) uses as pointer the RAM byte holding R0 (addr[0]=0) or R1 (addr[0]=1) of the active bank. It reaches RAM at that pointer for every pointer value, 80h to FFh included, and never drives the SFR port.
- R4: Stack mode (mode 3) uses addr itself as a RAM address over the full 0 to FFh range and never drives the SFR port.
- R5: Bit mode (mode 4) with bit address below 80h selects RAM byte 20h + (addr >> 3), bit addr & 7. A bit read returns that bit on `rdata_o[0]` with `rdata_o[7:1]` zero.
- R6: Bit mode with bit address 80h or above selects the SFR at addr & F8h, bit addr & 7, for both reads and writes.
- R7: A bit write of value `wdata_i[0]` changes only the selected bit. `busy_o` is high for exactly the one cycle after the accepting edge, and the merged byte is written at the following edge.
- R8: A request presented while `busy_o` is high writes neither RAM nor any SFR.
- R9: After reset, `busy_o` is low and every RAM byte reads zero.
- R10: A direct write with addr 80h or above drives `sfr_we_o` with `sfr_addr_o` = addr and `sfr_wdata_o` = `wdata_i`, and leaves RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| mode_i | input | 3 | 0 register, 1 direct, 2 indirect, 3 stack, 4 bit |
| addr_i | input | 8 | Byte, register, pointer-select, stack or bit address |
| bank_i | input | 2 | Working-register bank select from the status word |
| wdata_i | input | 8 | Write byte; bit 0 is the value for bit writes |
| rdata_o | output | 8 | Read byte, or the selected bit in bit 0 |
| busy_o | output | 1 | Write clock of a bit read-modify-write |
| sfr_addr_o | output | 8 | SFR address |
| sfr_rd_o | output | 1 | SFR read strobe |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_rdata_i | input | 8 | SFR read data |

## Verification
A bit write's second cycle can coincide with a fresh request, because the write port belongs to the pending read-modify-write while the new request asks for it too. The bench starts a RAM bit write and, in the busy cycle, holds a direct write to RAM and then to an SFR on the inputs. It judges the outcome by later reads: the target bytes must still be zero and the bit's byte must hold exactly the merged value. The indirect path also relies on the register write that set up its pointer, and the bench orders those accesses back to back.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [2:0] {
    MODE_REG = 3'd0,
    MODE_DIR = 3'd1,
    MODE_IND = 3'd2,
    MODE_STK = 3'd3,
    MODE_BIT = 3'd4
  } acc_mode_e;
endpackage

// File: rtl/idata_addr_decode.sv
module idata_addr_decode
  import idata_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned REG_W    = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20,
  localparam int unsigned SEL_W   = $clog2(DW)
) (
  input  acc_mode_e         mode_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DW-1:0]     ptr_byte_i,
  output logic [AW-1:0]     ptr_addr_o,
  output logic [AW-1:0]     tgt_addr_o,
  output logic              tgt_sfr_o,
  output logic              is_bit_o,
  output logic [SEL_W-1:0]  bit_sel_o
);
  logic [AW-1:0] reg_addr;

  // R0/R1 of the active bank hold the indirect pointer
  assign ptr_addr_o = AW'({bank_i, (REG_W)'(addr_i[0])});
  assign reg_addr   = AW'({bank_i, addr_i[REG_W-1:0]});
  assign bit_sel_o  = addr_i[SEL_W-1:0];

  always_comb begin
    tgt_addr_o = addr_i;
    tgt_sfr_o  = 1'b0;
    is_bit_o   = 1'b0;
    unique case (mode_i)
      MODE_REG: tgt_addr_o = reg_addr;
      MODE_IND: tgt_addr_o = AW'(ptr_byte_i);
      MODE_STK: tgt_addr_o = addr_i;
      MODE_BIT: begin
        is_bit_o = 1'b1;
        if (addr_i[AW-1]) begin
          tgt_addr_o = {addr_i[AW-1:SEL_W], {SEL_W{1'b0}}};
          tgt_sfr_o  = 1'b1;
        end else begin
          tgt_addr_o = BIT_BASE + AW'(addr_i[AW-2:SEL_W]);
        end
      end
      default: begin
        tgt_addr_o = addr_i;
        tgt_sfr_o  = addr_i[AW-1];
      end
    endcase
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ptr_addr_i,
  output logic [DW-1:0] ptr_data_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign ptr_data_o = mem_q[ptr_addr_i];
  assign rd_data_o  = mem_q[rd_addr_i];
endmodule

// File: rtl/idata_bit_rmw.sv
module idata_bit_rmw #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned SEL_W = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sfr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             bit_val_i,
  input  logic [DW-1:0]    byte_i,
  output logic             busy_o,
  output logic             wr_ram_o,
  output logic             wr_sfr_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o
);
  logic          busy_q, sfr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, merged;

  always_comb begin
    merged            = byte_i;
    merged[bit_sel_i] = bit_val_i;
  end

  // read clock: capture merged byte; write clock: issue it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sfr_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= start_i;
      if (start_i) begin
        sfr_q  <= sfr_i;
        addr_q <= addr_i;
        data_q <= merged;
      end
    end
  end

  assign busy_o    = busy_q;
  assign wr_ram_o  = busy_q & ~sfr_q;
  assign wr_sfr_o  = busy_q & sfr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  p_busy_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
  p_start_then_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
  import idata_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned REG_W  = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20,
  localparam int unsigned SEL_W = $clog2(DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        mode_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              busy_o,
  output logic [AW-1:0]     sfr_addr_o,
  output logic              sfr_rd_o,
  output logic              sfr_we_o,
  output logic [DW-1:0]     sfr_wdata_o,
  input  logic [DW-1:0]     sfr_rdata_i
);
  acc_mode_e        mode;
  logic [AW-1:0]    ptr_addr, tgt_addr, rmw_addr, ram_wa;
  logic [DW-1:0]    ptr_byte, ram_rd, rd_byte, rmw_data, wr_data;
  logic             tgt_sfr, is_bit, accept, byte_wr, bit_wr;
  logic             rmw_busy, rmw_ram, rmw_sfr, ram_we;
  logic [SEL_W-1:0] bit_sel;

  assign mode = acc_mode_e'(mode_i);

  idata_addr_decode #(
    .AW(AW), .DW(DW), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_decode (
    .mode_i    (mode),
    .addr_i    (addr_i),
    .bank_i    (bank_i),
    .ptr_byte_i(ptr_byte),
    .ptr_addr_o(ptr_addr),
    .tgt_addr_o(tgt_addr),
    .tgt_sfr_o (tgt_sfr),
    .is_bit_o  (is_bit),
    .bit_sel_o (bit_sel)
  );

  idata_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_addr_i(ptr_addr),
    .ptr_data_o(ptr_byte),
    .rd_addr_i (tgt_addr),
    .rd_data_o (ram_rd),
    .we_i      (ram_we),
    .wa_i      (ram_wa),
    .wd_i      (wr_data)
  );

  // held-off requests are dropped while the rmw owns the write port
  assign accept  = req_i & ~rmw_busy;
  assign byte_wr = accept & we_i & ~is_bit;
  assign bit_wr  = accept & we_i & is_bit;
  assign rd_byte = tgt_sfr ? sfr_rdata_i : ram_rd;

  idata_bit_rmw #(.AW(AW), .DW(DW)) u_rmw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (bit_wr),
    .sfr_i    (tgt_sfr),
    .addr_i   (tgt_addr),
    .bit_sel_i(bit_sel),
    .bit_val_i(wdata_i[0]),
    .byte_i   (rd_byte),
    .busy_o   (rmw_busy),
    .wr_ram_o (rmw_ram),
    .wr_sfr_o (rmw_sfr),
    .wr_addr_o(rmw_addr),
    .wr_data_o(rmw_data)
  );

  assign ram_we      = rmw_busy ? rmw_ram : (byte_wr & ~tgt_sfr);
  assign ram_wa      = rmw_busy ? rmw_addr : tgt_addr;
  assign wr_data     = rmw_busy ? rmw_data : wdata_i;
  assign sfr_we_o    = rmw_busy ? rmw_sfr : (byte_wr & tgt_sfr);
  assign sfr_rd_o    = accept & tgt_sfr & (~we_i | is_bit);
  assign sfr_addr_o  = rmw_busy ? rmw_addr : tgt_addr;
  assign sfr_wdata_o = wr_data;
  assign busy_o      = rmw_busy;
  assign rdata_o     = is_bit ? DW'(rd_byte[bit_sel]) : rd_byte;

  p_ind_no_sfr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i == 3'd2) |-> (!sfr_rd_o && !sfr_we_o));
  p_stk_no_sfr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i == 3'd3) |-> (!sfr_rd_o && !sfr_we_o));
  p_dir_low_ram_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i == 3'd1 && !addr_i[AW-1]) |-> (!sfr_rd_o && !sfr_we_o));
  p_bit_sfr_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sfr_we_o) |-> (sfr_addr_o[SEL_W-1:0] == '0 && sfr_addr_o[AW-1]));
  p_busy_one_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ram_we ^ sfr_we_o));
endmodule

// File: tb/idata_access_unit_bench.sv
`timescale 1ns/1ps
module idata_access_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic [1:0] bank = '0;
  logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;
  logic       busy, sfr_rd, sfr_we;
  logic [7:0] sfr_mem [128];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idata_access_unit u_idata_access_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .mode_i(mode),
    .addr_i(addr), .bank_i(bank), .wdata_i(wdata), .rdata_o(rdata),
    .busy_o(busy), .sfr_addr_o(sfr_addr), .sfr_rd_o(sfr_rd),
    .sfr_we_o(sfr_we), .sfr_wdata_o(sfr_wdata), .sfr_rdata_i(sfr_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) sfr_mem[i] <= 8'h00;
    end else if (sfr_we) begin
      sfr_mem[sfr_addr[6:0]] <= sfr_wdata;
    end
  end
  assign sfr_rdata = sfr_mem[sfr_addr[6:0]];

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic w, input logic [1:0] b,
                       input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; mode = m; bank = b; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
  endtask

  // {mode, we, bank, addr, wdata, expected rdata, expected sfr_rd}
  localparam int NV = 17;
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 1'b1, 2'd0, 8'h00, 8'h90, 8'h00, 1'b0}, // R1 bank0 R0 = 90h
    {3'd0, 1'b1, 2'd2, 8'h01, 8'h40, 8'h00, 1'b0}, // R1 bank2 R1 = 40h
    {3'd1, 1'b1, 2'd0, 8'h90, 8'h3C, 8'h00, 1'b0}, // R10 SFR 90h
    {3'd2, 1'b1, 2'd0, 8'h00, 8'hA5, 8'h00, 1'b0}, // R3 @R0 -> RAM 90h
    {3'd1, 1'b0, 2'd0, 8'h90, 8'h00, 8'h3C, 1'b1}, // R2 direct high = SFR
    {3'd2, 1'b0, 2'd0, 8'h00, 8'h00, 8'hA5, 1'b0}, // R3 upper RAM
    {3'd3, 1'b0, 2'd0, 8'h90, 8'h00, 8'hA5, 1'b0}, // R4 stack upper RAM
    {3'd2, 1'b1, 2'd2, 8'h01, 8'h77, 8'h00, 1'b0}, // R3 bank2 @R1 -> 40h
    {3'd1, 1'b0, 2'd0, 8'h40, 8'h00, 8'h77, 1'b0}, // R2 direct low
    {3'd1, 1'b0, 2'd0, 8'h11, 8'h00, 8'h40, 1'b0}, // R1 bank2 R1 at 11h
    {3'd0, 1'b0, 2'd2, 8'h01, 8'h00, 8'h40, 1'b0}, // R1 reg read
    {3'd0, 1'b0, 2'd0, 8'h01, 8'h00, 8'h00, 1'b0}, // R1 other bank
    {3'd3, 1'b1, 2'd0, 8'hFF, 8'h12, 8'h00, 1'b0}, // R4 push to FFh
    {3'd1, 1'b0, 2'd0, 8'hFF, 8'h00, 8'h00, 1'b1}, // R4 SFR FFh untouched
    {3'd3, 1'b0, 2'd0, 8'hFF, 8'h00, 8'h12, 1'b0}, // R4 pop from FFh
    {3'd0, 1'b1, 2'd3, 8'h07, 8'hEE, 8'h00, 1'b0}, // R1 bank3 R7
    {3'd1, 1'b0, 2'd0, 8'h1F, 8'h00, 8'hEE, 1'b0}  // R1 R7 at 1Fh
  };

  initial begin
    #250000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-R got=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 busy after reset", {7'b0, busy}, 8'h00);
    rst_n = 1'b1;
    drive(3'd1, 1'b0, 2'd0, 8'h20, 8'h00);
    check("R9 RAM 20h zero", rdata, 8'h00);
    drive(3'd3, 1'b0, 2'd0, 8'hC3, 8'h00);
    check("R9 RAM C3h zero", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      drive(v[30:28], v[27], v[26:25], v[24:17], v[16:9]);
      if (v[27] && v[30:28] == 3'd1 && v[24]) begin
        check($sformatf("R10 sfr_we vec %0d", i), {7'b0, sfr_we}, 8'h01);
        check($sformatf("R10 sfr_addr vec %0d", i), sfr_addr, v[24:17]);
      end
      if (!v[27]) begin
        check($sformatf("R1-4 rdata vec %0d", i), rdata, v[8:1]);
        check($sformatf("R2 sfr_rd vec %0d", i), {7'b0, sfr_rd}, {7'b0, v[0]});
      end
    end
    idle();

    // R5 / R7: RAM bit write 0Bh -> byte 21h bit 3
    drive(3'd4, 1'b1, 2'd0, 8'h0B, 8'h01);
    @(posedge clk); #1;
    check("R7 busy in write clock", {7'b0, busy}, 8'h01);
    req = 1'b0;
    @(posedge clk); #1;
    check("R7 busy drops", {7'b0, busy}, 8'h00);
    drive(3'd1, 1'b0, 2'd0, 8'h21, 8'h00);
    check("R5 byte 21h after set bit3", rdata, 8'h08);
    drive(3'd4, 1'b1, 2'd0, 8'h0F, 8'h01);
    idle(); idle();
    drive(3'd4, 1'b1, 2'd0, 8'h0B, 8'h00);
    idle(); idle();
    drive(3'd1, 1'b0, 2'd0, 8'h21, 8'h00);
    check("R7 only bit3 cleared", rdata, 8'h80);
    drive(3'd4, 1'b0, 2'd0, 8'h0F, 8'h00);
    check("R5 bit read 0Fh", rdata, 8'h01);
    drive(3'd4, 1'b0, 2'd0, 8'h0B, 8'h00);
    check("R5 bit read 0Bh", rdata, 8'h00);

    // R6: SFR bit write D5h -> SFR D0h bit 5
    drive(3'd1, 1'b1, 2'd0, 8'hD0, 8'h81);
    drive(3'd4, 1'b1, 2'd0, 8'hD5, 8'h01);
    check("R6 sfr_rd on bit read clock", {7'b0, sfr_rd}, 8'h01);
    @(posedge clk); #1;
    req = 1'b0;
    check("R6 write clock sfr_we", {7'b0, sfr_we}, 8'h01);
    check("R6 write clock sfr_addr", sfr_addr, 8'hD0);
    idle();
    drive(3'd1, 1'b0, 2'd0, 8'hD0, 8'h00);
    check("R6 SFR D0h merged", rdata, 8'hA1);
    drive(3'd4, 1'b0, 2'd0, 8'hD7, 8'h00);
    check("R6 bit read D7h", rdata, 8'h01);
    drive(3'd4, 1'b0, 2'd0, 8'hD6, 8'h00);
    check("R6 bit read D6h", rdata, 8'h00);

    // R8: requests during write clock are dropped
    drive(3'd4, 1'b1, 2'd0, 8'h00, 8'h01);
    drive(3'd1, 1'b1, 2'd0, 8'h30, 8'h55);
    check("R8 busy during held request", {7'b0, busy}, 8'h01);
    idle();
    drive(3'd4, 1'b1, 2'd1, 8'h01, 8'h01);
    drive(3'd1, 1'b1, 2'd0, 8'hE0, 8'h66);
    idle();
    drive(3'd1, 1'b0, 2'd0, 8'h30, 8'h00);
    check("R8 RAM 30h untouched", rdata, 8'h00);
    drive(3'd1, 1'b0, 2'd0, 8'hE0, 8'h00);
    check("R8 SFR E0h untouched", rdata, 8'h00);
    drive(3'd1, 1'b0, 2'd0, 8'h20, 8'h00);
    check("R8 R5 byte 20h bits 0 and 1", rdata, 8'h03);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule